// File: doc/BRIEF.md
# Codec Register Write Framer

This block turns a single audio-codec register update into a complete two-byte write transaction on a shared two-wire serial bus. A client hands it a 7-bit register index and a 9-bit value over a valid/ready request channel. The framer packs the pair into two payload bytes, puts the fixed device address byte in front of them, and drives a byte-level bus master one command at a time: a START, three byte writes, then a STOP. The master block handles the physical line signalling.

The request channel follows the usual valid/ready rules. A request transfers on the rising clock edge where both `req_valid` and `req_ready` are high. The client may hold `req_valid` high for as long as it likes. The framer accepts only one request at a time and keeps `req_ready` low until that request has finished, so back-pressure lasts for the whole bus transaction.

The command channel to the master is also valid/ready. The framer holds each command steady until the master takes it, and it waits for the one-cycle response to that command before it issues the next one. A clean transaction ends with a `done` pulse and `done_err` low. If the target does not acknowledge a byte, or the bus stays busy for too long before the START, the `done` pulse carries `done_err` high.

Top module: `codec_wr_framer`

## Requirements
- R1: After reset and whenever no request is in progress, `req_ready` is 1, while `done` and `cmd_valid` are 0.
- R2: A request is accepted on a clock edge with `req_valid` and `req_ready` both high. `req_ready` then stays 0 up to and including the cycle of that request's `done` pulse, and returns to 1 in the following cycle.
- R3: Before issuing START, the framer waits for `bus_busy` to be 0. If `bus_busy` stays 1 for BUSY_TIMEOUT consecutive cycles, counting from the first cycle after acceptance, the framer issues no command at all. Instead, `done` rises with `done_err` = 1 in the next cycle, which is BUSY_TIMEOUT cycles after the accepting edge.
- R4: A fully acknowledged request produces exactly this command sequence: START (`cmd_op` = 2'b01), three WRITE commands (`cmd_op` = 2'b10), then STOP (`cmd_op` = 2'b11). Each command is issued only after the response (`rsp_valid`) to the previous one.
- R5: The first WRITE byte is DEV_ADDR (default 8'h34) with bit 0 forced to 0.
- R6: The second WRITE byte is the register index in bits 7:1, with bit 8 of the data value in bit 0.
- R7: The third WRITE byte is bits 7:0 of the data value.
- R8: A response with `rsp_nack` = 1 to a WRITE ends the byte transmission. No further WRITE is issued, the next command is STOP, and the `done` pulse carries `done_err` = 1.
- R9: `done` is high for exactly one cycle per accepted request. `done_err` is 0 when every byte was acknowledged and the bus became free in time.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_op` and `cmd_byte` hold steady. No new command is offered while a response is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Framer can accept a request |
| req_reg | input | 7 | Codec register index |
| req_data | input | 9 | Codec register value |
| bus_busy | input | 1 | Bus is held by another master |
| cmd_valid | output | 1 | Command offered to the bus master |
| cmd_ready | input | 1 | Bus master takes the command |
| cmd_op | output | 2 | 01 START, 10 WRITE, 11 STOP |
| cmd_byte | output | 8 | Byte to send for a WRITE, 0 otherwise |
| rsp_valid | input | 1 | One-cycle completion of the outstanding command |
| rsp_nack | input | 1 | Written byte was not acknowledged |
| done | output | 1 | One-cycle end-of-request pulse |
| done_err | output | 1 | Request failed (NACK or bus timeout), valid with done |

## Verification
The bench covers the extreme payloads: index 0x7F with value 0x1FF, all zeros, and a value with bit 8 clear under an index with its top bit set. A framer that put the value's top bit in the wrong place, or shifted the index wrongly, would corrupt one of those bytes. A NACK is injected at each of the three byte positions. A design that kept writing after a NACK, skipped the STOP, or lost the error flag would show up as an extra command, a missing STOP or a wrong `done_err`. A short busy spell must only delay the START. A busy bus that never frees must end exactly at the timeout with no command issued, which catches off-by-one timers and a START sent onto a busy bus. The master model also stalls `cmd_ready` and delays responses, so any command that changes or advances before its handshake completes would break the expected stream.

// File: rtl/codec_wr_pkg.sv
package codec_wr_pkg;

  localparam int REG_W     = 7;
  localparam int DATA_W    = 9;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 3;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_START = 2'b01,
    OP_WRITE = 2'b10,
    OP_STOP  = 2'b11
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CMD,
    ST_RSP,
    ST_DONE
  } seq_state_e;

  function automatic logic [BYTE_W-1:0] write_addr(input logic [BYTE_W-1:0] a);
    return {a[BYTE_W-1:1], 1'b0};
  endfunction

endpackage

// File: rtl/codec_wr_pack.sv
module codec_wr_pack
  import codec_wr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'h34
) (
  input  logic [REG_W-1:0]                   reg_idx,
  input  logic [DATA_W-1:0]                  reg_val,
  output logic [NUM_BYTES-1:0][BYTE_W-1:0]   bytes
);

  // Slot 0 addresses the device, slot 1 carries the index plus the value MSB,
  // slot 2 carries the low value bits.
  always_comb begin
    bytes[0] = write_addr(DEV_ADDR);
    bytes[1] = {reg_idx, reg_val[DATA_W-1]};
    bytes[2] = reg_val[BYTE_W-1:0];
  end

endmodule

// File: rtl/codec_wr_idle_wait.sv
module codec_wr_idle_wait #(
  parameter int TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic busy_tick,
  output logic expired
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (busy_tick && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  // High during the TIMEOUT-th consecutive busy cycle of the wait.
  assign expired = busy_tick && (cnt == LAST);

endmodule

// File: rtl/codec_wr_seq.sv
module codec_wr_seq
  import codec_wr_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic                               bus_busy,
  output logic                               wait_clear,
  output logic                               wait_tick,
  input  logic                               wait_expired,
  input  logic [NUM_BYTES-1:0][BYTE_W-1:0]   bytes,
  output logic                               cmd_valid,
  input  logic                               cmd_ready,
  output logic [1:0]                         cmd_op,
  output logic [BYTE_W-1:0]                  cmd_byte,
  input  logic                               rsp_valid,
  input  logic                               rsp_nack,
  output logic                               done,
  output logic                               done_err
);

  localparam int PH_W = $clog2(NUM_BYTES + 2);
  localparam logic [PH_W-1:0] PH_START = '0;
  localparam logic [PH_W-1:0] PH_STOP  = PH_W'(NUM_BYTES + 1);

  seq_state_e      state;
  logic [PH_W-1:0] phase;
  logic            err;
  logic            is_write;

  assign is_write = (phase != PH_START) && (phase != PH_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= PH_START;
      err   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state <= ST_WAIT;
            phase <= PH_START;
            err   <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (!bus_busy) begin
            state <= ST_CMD;
          end else if (wait_expired) begin
            state <= ST_DONE;
            err   <= 1'b1;
          end
        end
        ST_CMD: begin
          if (cmd_ready) state <= ST_RSP;
        end
        ST_RSP: begin
          if (rsp_valid) begin
            if (is_write && rsp_nack) begin
              err   <= 1'b1;
              phase <= PH_STOP;
              state <= ST_CMD;
            end else if (phase == PH_STOP) begin
              state <= ST_DONE;
            end else begin
              phase <= phase + 1'b1;
              state <= ST_CMD;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_byte = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (phase == PH_W'(i + 1)) cmd_byte = bytes[i];
    end
  end

  always_comb begin
    if (phase == PH_START)     cmd_op = OP_START;
    else if (phase == PH_STOP) cmd_op = OP_STOP;
    else                       cmd_op = OP_WRITE;
  end

  assign req_ready  = (state == ST_IDLE);
  assign cmd_valid  = (state == ST_CMD);
  assign done       = (state == ST_DONE);
  assign done_err   = (state == ST_DONE) && err;
  assign wait_clear = (state == ST_IDLE);
  assign wait_tick  = (state == ST_WAIT) && bus_busy;

endmodule

// File: rtl/codec_wr_framer.sv
module codec_wr_framer
  import codec_wr_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR     = 8'h34,
  parameter int         BUSY_TIMEOUT = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [6:0] req_reg,
  input  logic [8:0] req_data,
  input  logic       bus_busy,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic [7:0] cmd_byte,
  input  logic       rsp_valid,
  input  logic       rsp_nack,
  output logic       done,
  output logic       done_err
);

  logic [REG_W-1:0]                 reg_q;
  logic [DATA_W-1:0]                data_q;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes;
  logic                             wait_clear;
  logic                             wait_tick;
  logic                             wait_expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      data_q <= '0;
    end else if (req_valid && req_ready) begin
      reg_q  <= req_reg;
      data_q <= req_data;
    end
  end

  codec_wr_pack #(.DEV_ADDR(DEV_ADDR)) u_pack (
    .reg_idx (reg_q),
    .reg_val (data_q),
    .bytes   (bytes)
  );

  codec_wr_idle_wait #(.TIMEOUT(BUSY_TIMEOUT)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (wait_clear),
    .busy_tick (wait_tick),
    .expired   (wait_expired)
  );

  codec_wr_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .bus_busy     (bus_busy),
    .wait_clear   (wait_clear),
    .wait_tick    (wait_tick),
    .wait_expired (wait_expired),
    .bytes        (bytes),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_op       (cmd_op),
    .cmd_byte     (cmd_byte),
    .rsp_valid    (rsp_valid),
    .rsp_nack     (rsp_nack),
    .done         (done),
    .done_err     (done_err)
  );

endmodule

// File: rtl/codec_wr_framer_chk.sv
module codec_wr_framer_chk #(
  parameter logic [7:0] DEV_ADDR = 8'h34
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       bus_busy,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_byte,
  input logic       rsp_valid,
  input logic       rsp_nack,
  input logic       done,
  input logic       done_err
);

  logic       pending;
  logic       outstanding;
  logic       nacked;
  logic [1:0] last_op;
  logic [2:0] wr_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      outstanding <= 1'b0;
      nacked      <= 1'b0;
      last_op     <= 2'b00;
      wr_idx      <= '0;
    end else begin
      if (req_valid && req_ready) begin
        pending <= 1'b1;
        nacked  <= 1'b0;
      end else if (done) begin
        pending <= 1'b0;
      end
      if (cmd_valid && cmd_ready) begin
        outstanding <= 1'b1;
        last_op     <= cmd_op;
        if (cmd_op == 2'b01)      wr_idx <= '0;
        else if (cmd_op == 2'b10) wr_idx <= wr_idx + 1'b1;
      end else if (rsp_valid) begin
        outstanding <= 1'b0;
        if (outstanding && rsp_nack && last_op == 2'b10) nacked <= 1'b1;
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> (!cmd_valid && !done));

  p_ready_held_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !req_ready);

  p_start_on_idle_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid) && cmd_op == 2'b01) |-> $past(!bus_busy));

  p_addr_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b10 && wr_idx == 3'd0) |-> cmd_byte == {DEV_ADDR[7:1], 1'b0});

  p_stop_after_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nacked && cmd_valid) |-> cmd_op == 2'b11);

  p_nack_flags_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nacked) |-> done_err);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !cmd_valid);

endmodule

bind codec_wr_framer codec_wr_framer_chk #(.DEV_ADDR(DEV_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .bus_busy  (bus_busy),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_byte  (cmd_byte),
  .rsp_valid (rsp_valid),
  .rsp_nack  (rsp_nack),
  .done      (done),
  .done_err  (done_err)
);

// File: tb/codec_wr_framer_test.sv
module codec_wr_framer_test;

  localparam int TMO = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [6:0] req_reg = '0;
  logic [8:0] req_data = '0;
  logic       bus_busy = 1'b0;
  logic       cmd_valid;
  logic       cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic       rsp_valid = 1'b0;
  logic       rsp_nack = 1'b0;
  logic       done;
  logic       done_err;

  int checks = 0;
  int errors = 0;
  int nack_at = -1;
  int wr_seen = 0;
  int ncmd = 0;
  bit finished = 0;

  logic [1:0] exp_op[$];
  logic [7:0] exp_byte[$];
  string      exp_tag[$];

  always #10 clk = ~clk;

  codec_wr_framer #(.DEV_ADDR(8'h34), .BUSY_TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_reg(req_reg), .req_data(req_data),
    .bus_busy(bus_busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
    .done(done), .done_err(done_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor and bus master model: pops the expected stream on each handshake.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        repeat (ncmd % 3) @(negedge clk);
        ncmd++;
        if (exp_op.size() == 0) begin
          check(0, "R4 unexpected command", int'(cmd_op), 0);
        end else begin
          logic [1:0] eo;
          logic [7:0] eb;
          string      et;
          eo = exp_op.pop_front();
          eb = exp_byte.pop_front();
          et = exp_tag.pop_front();
          check(cmd_op == eo, {et, " op"}, int'(cmd_op), int'(eo));
          if (eo == 2'b10) check(cmd_byte == eb, {et, " byte"}, int'(cmd_byte), int'(eb));
        end
        begin
          logic [1:0] op_now;
          op_now = cmd_op;
          cmd_ready = 1'b1;
          @(negedge clk);
          cmd_ready = 1'b0;
          repeat (ncmd % 2) @(negedge clk);
          if (op_now == 2'b01) wr_seen = 0;
          rsp_valid = 1'b1;
          rsp_nack  = (op_now == 2'b10) && (wr_seen == nack_at);
          if (op_now == 2'b10) wr_seen++;
        end
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_nack  = 1'b0;
      end
    end
  end

  // Driver: pushes the expected command stream, then issues the request.
  task automatic send(input logic [6:0] r, input logic [8:0] d,
                      input int nack, input int busy_cyc, input bit stuck);
    int cyc;
    bit exp_err;
    logic [7:0] b[3];
    b[0] = 8'h34;
    b[1] = {r, d[8]};
    b[2] = d[7:0];
    exp_err = stuck || (nack >= 0);
    nack_at = nack;
    if (!stuck) begin
      exp_op.push_back(2'b01); exp_byte.push_back(8'h00); exp_tag.push_back("R4 start");
      for (int i = 0; i < 3; i++) begin
        if (nack < 0 || i <= nack) begin
          exp_op.push_back(2'b10);
          exp_byte.push_back(b[i]);
          exp_tag.push_back(i == 0 ? "R5 address" : (i == 1 ? "R6 index byte" : "R7 value byte"));
        end
      end
      exp_op.push_back(2'b11); exp_byte.push_back(8'h00);
      exp_tag.push_back(nack >= 0 ? "R8 stop after nack" : "R4 stop");
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready before request", int'(req_ready), 1);
    req_reg   = r;
    req_data  = d;
    req_valid = 1'b1;
    bus_busy  = (busy_cyc > 0) || stuck;
    cyc = 0;
    @(negedge clk);
    cyc = 1;
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2 ready low after accept", int'(req_ready), 0);
    while (!done && cyc < 400) begin
      if (!stuck && cyc >= busy_cyc) bus_busy = 1'b0;
      if (req_ready) check(0, "R2 ready during transfer", 1, 0);
      @(negedge clk);
      cyc++;
    end
    bus_busy = 1'b0;
    check(done == 1'b1, "R9 done reached", int'(done), 1);
    check(req_ready == 1'b0, "R2 ready low at done", int'(req_ready), 0);
    check(done_err == exp_err, exp_err ? (stuck ? "R3 timeout error" : "R8 nack error")
                                       : "R9 clean done_err", int'(done_err), int'(exp_err));
    if (stuck) check(cyc == TMO + 1, "R3 timeout latency", cyc, TMO + 1);
    check(exp_op.size() == 0, "R4 all commands issued", exp_op.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", int'(done), 0);
    check(req_ready == 1'b1, "R2 ready returns", int'(req_ready), 1);
    exp_op.delete(); exp_byte.delete(); exp_tag.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    check(done == 1'b0 && cmd_valid == 1'b0, "R1 reset quiet", int'({done, cmd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && !cmd_valid, "R1 idle after reset", int'(req_ready), 1);

    send(7'h05, 9'h123, -1, 0, 0);
    send(7'h7F, 9'h1FF, -1, 0, 0);
    send(7'h00, 9'h000, -1, 0, 0);
    send(7'h40, 9'h0FF, -1, 0, 0);
    send(7'h2A, 9'h155, 0, 0, 0);
    send(7'h15, 9'h0AA, 1, 0, 0);
    send(7'h7F, 9'h100, 2, 0, 0);
    send(7'h0C, 9'h081, -1, 5, 0);
    send(7'h33, 9'h1C3, -1, 0, 1);
    send(7'h01, 9'h001, -1, 0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule